// File: doc/BRIEF.md
# Vector Feed Interface Control and Status Registers

This block is the register front end of an unpacking interface that moves packets from a DMA channel into a vector coprocessor. It decodes 32-bit bus writes and reads onto a command register (reset, force break, stop, stall cancel), a status word, an error register, a mode register, a mark register, and two banks of fill words: four row words and four column words. The unpack datapath, the DMA engine and the FIFO storage sit outside. Only their handshakes are modelled here: event inputs from the datapath, channel state inputs from the DMA engine, and three one-cycle control pulses back to it.

The block holds the stall, break, interrupt and error flags. It drives a stop pulse when a force break is issued, a restart pulse when a real stall is cancelled, and a terminate pulse when the transfer direction flips under an active channel. On the second-instance variant (`SECOND_INST=1`), a writable direction bit selects memory-to-interface or interface-to-memory transfer, and a FIFO quantity count is loaded when the direction is set.

Registers sit at 16-byte spacing. Word index = `addr[ADDR_W-1:4]`. Index 0 is status, 1 is command, 2 is error, 3 is mark and 4 is mode. Indices 8–11 are the row words and 12–15 are the column words.

Top module: `vpu_feed_csr`

## Requirements
- R1: After `rst_n` is low, every flag, the FIFO count, the error, mark and mode registers and all fill words read as zero. The status word layout is: [1:0] processing state, [2] mark seen, [3] direction, [4] stop stall, [5] force break, [6] interrupt stall, [7] interrupt, [8] error 0, [9] error 1, [28:24] FIFO count. All other bits are zero.
- R2: Each of the four row words (0x80–0xB0) and the four column words (0xC0–0xF0) is a 32-bit word. Each can be written and read back at its own address without disturbing the others.
- R3: Command bit 1 (force break) sets status bit 5 and issues a one-cycle `dma_stop` pulse. While any of status bits 4–6 is set, the processing state reads 0 (idle). Otherwise it follows `proc_state`.
- R4: Command bit 2 (stop) sets status bit 4 and forces the processing state to idle without pulsing `dma_stop`.
- R5: Command bit 3 (stall cancel) clears status bits 4 through 9.
- R6: A stall cancel pulses `dma_restart` only if one of status bits 4–6 was set and `dma_active` is high. On the second instance, the direction bit must also be 0.
- R7: Command bit 0 (reset) clears the status word (including direction and FIFO count) and the error register. The row and column words and the mode register keep their values.
- R8: A write to the mark register clears status bit 2, which `evt_mark` sets. `evt_int` sets bits 6 and 7, and `evt_err[1:0]` sets bits 9:8.
- R9: A status write changes only bit 3 (direction). All other written bits have no effect.
- R10: Writing direction 1 loads the FIFO count with min(16, `dl_size`). Writing direction 0 zeroes the count and pulses `dma_restart` if `dma_active` is high.
- R11: A status write that changes the direction while `dma_active` is high pulses `dma_term` if `dma_qwc_nz` is high or none of status bits 4–7 is set.
- R12: Reads of the command register and of unused indices return zero. Every write takes effect, and every pulse appears, in the cycle after the write strobe.
- R13: The error register (3 bits), mode register (2 bits) and mark value (16 bits) store written data and read it back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Bus byte address |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data for `addr` (combinational) |
| proc_state | input | 2 | Processing state reported by the datapath |
| evt_mark | input | 1 | Datapath saw a mark |
| evt_int | input | 1 | Datapath hit an interrupt and stalled |
| evt_err | input | 2 | Datapath error events |
| dma_active | input | 1 | DMA channel start bit |
| dma_qwc_nz | input | 1 | DMA channel still has quadwords |
| dl_size | input | DL_W | Pending download size in quadwords |
| dma_stop | output | 1 | One-cycle pulse: stop the channel |
| dma_restart | output | 1 | One-cycle pulse: restart the channel |
| dma_term | output | 1 | One-cycle pulse: end the channel, clear its count, raise its interrupt |
| fill_row | output | NFILL*32 | Row fill words, word 0 in the low bits |
| fill_col | output | NFILL*32 | Column fill words, word 0 in the low bits |

## Verification
The bound checker watches, on every cycle, that a force break sets its flag and pulses stop. It also checks that a stop never pulses stop, that a cancel leaves bits 4–9 clear, and that a mark write leaves the mark flag clear. Further per-cycle checks cover the idle state during any stall, that the FIFO count never exceeds 16, that a restart always follows a status or command write, and that a command reset leaves the fill words untouched. Other behaviour depends on the ordered history of events, channel state and direction, and only the bench's scenarios show it. This covers which gating blocks a restart, when a direction flip terminates the channel, the clamp of the download size, and the exact status word after each sequence.

// File: rtl/vpu_feed_csr_pkg.sv
package vpu_feed_csr_pkg;

    localparam int unsigned IDX_STAT = 0;
    localparam int unsigned IDX_CMD  = 1;
    localparam int unsigned IDX_ERR  = 2;
    localparam int unsigned IDX_MARK = 3;
    localparam int unsigned IDX_MODE = 4;

    localparam int unsigned CMD_RST = 0;
    localparam int unsigned CMD_FBK = 1;
    localparam int unsigned CMD_STP = 2;
    localparam int unsigned CMD_STC = 3;

    localparam int unsigned FQC_W   = 5;
    localparam int unsigned FQC_MAX = 16;
    localparam int unsigned FQC_LSB = 24;
    localparam int unsigned ERR_W   = 3;
    localparam int unsigned MODE_W  = 2;
    localparam int unsigned MARK_W  = 16;
    localparam int unsigned DIR_BIT = 3;

    // status flags, bit 0 at the right
    typedef struct packed {
        logic       err1;
        logic       err0;
        logic       irq;
        logic       istall;
        logic       fbrk;
        logic       sstall;
        logic       dir;
        logic       mark;
        logic [1:0] ps;
    } flags_t;

endpackage

// File: rtl/vpu_feed_csr_dec.sv
module vpu_feed_csr_dec
    import vpu_feed_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NFILL  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_stat,
    output logic              sel_cmd,
    output logic              sel_err,
    output logic              sel_mark,
    output logic              sel_mode,
    output logic [NFILL-1:0]  row_sel,
    output logic [NFILL-1:0]  col_sel
);
    localparam int unsigned IDX_W    = ADDR_W - 4;
    localparam int unsigned ROW_BASE = 2 * NFILL;
    localparam int unsigned COL_BASE = 3 * NFILL;

    logic [IDX_W-1:0] idx;
    logic [3:0]       unused_low;

    assign idx        = addr[ADDR_W-1:4];
    assign unused_low = addr[3:0];

    assign sel_stat = (idx == IDX_W'(IDX_STAT));
    assign sel_cmd  = (idx == IDX_W'(IDX_CMD));
    assign sel_err  = (idx == IDX_W'(IDX_ERR));
    assign sel_mark = (idx == IDX_W'(IDX_MARK));
    assign sel_mode = (idx == IDX_W'(IDX_MODE));

    for (genvar i = 0; i < NFILL; i++) begin : g_sel
        assign row_sel[i] = (idx == IDX_W'(ROW_BASE + i));
        assign col_sel[i] = (idx == IDX_W'(COL_BASE + i));
    end
endmodule

// File: rtl/vpu_feed_csr_fill.sv
module vpu_feed_csr_fill #(
    parameter int unsigned W = 32,
    parameter int unsigned N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [N-1:0]   sel,
    input  logic [W-1:0]   wdata,
    output logic [N*W-1:0] words
);
    logic [W-1:0] word_d [N];
    logic [W-1:0] word_q [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            word_d[i] = (we && sel[i]) ? wdata : word_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) word_q[i] <= '0;
        end else begin
            for (int i = 0; i < N; i++) word_q[i] <= word_d[i];
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign words[i*W +: W] = word_q[i];
    end
endmodule

// File: rtl/vpu_feed_csr.sv
module vpu_feed_csr
    import vpu_feed_csr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DL_W        = 8,
    parameter int unsigned NFILL       = 4,
    parameter bit          SECOND_INST = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [1:0]          proc_state,
    input  logic                evt_mark,
    input  logic                evt_int,
    input  logic [1:0]          evt_err,
    input  logic                dma_active,
    input  logic                dma_qwc_nz,
    input  logic [DL_W-1:0]     dl_size,
    output logic                dma_stop,
    output logic                dma_restart,
    output logic                dma_term,
    output logic [NFILL*32-1:0] fill_row,
    output logic [NFILL*32-1:0] fill_col
);
    localparam int unsigned FLAG_W = $bits(flags_t);
    localparam int unsigned GAP_W  = FQC_LSB - FLAG_W;
    localparam int unsigned TOP_W  = 32 - FQC_LSB - FQC_W;

    typedef struct packed {
        flags_t              f;
        logic [FQC_W-1:0]    fqc;
        logic [ERR_W-1:0]    errv;
        logic [MODE_W-1:0]   mode;
        logic [MARK_W-1:0]   markv;
        logic                stop;
        logic                restart;
        logic                term;
    } st_t;

    st_t d, q;

    logic sel_stat, sel_cmd, sel_err, sel_mark, sel_mode;
    logic [NFILL-1:0] row_sel, col_sel;
    logic [FQC_W-1:0] dl_clamped;
    logic             stalled_q, pend;
    logic [15:0]      unused_wdata;

    flags_t           flags_q;
    logic [FQC_W-1:0] fqc_q;

    assign unused_wdata = wdata[31:16];

    vpu_feed_csr_dec #(.ADDR_W(ADDR_W), .NFILL(NFILL)) u_dec (
        .addr     (addr),
        .sel_stat (sel_stat),
        .sel_cmd  (sel_cmd),
        .sel_err  (sel_err),
        .sel_mark (sel_mark),
        .sel_mode (sel_mode),
        .row_sel  (row_sel),
        .col_sel  (col_sel)
    );

    vpu_feed_csr_fill #(.W(32), .N(NFILL)) u_rows (
        .clk (clk), .rst_n (rst_n), .we (wr_en), .sel (row_sel),
        .wdata (wdata), .words (fill_row)
    );

    vpu_feed_csr_fill #(.W(32), .N(NFILL)) u_cols (
        .clk (clk), .rst_n (rst_n), .we (wr_en), .sel (col_sel),
        .wdata (wdata), .words (fill_col)
    );

    assign dl_clamped = (dl_size > DL_W'(FQC_MAX)) ? FQC_W'(FQC_MAX)
                                                  : dl_size[FQC_W-1:0];
    assign stalled_q  = q.f.sstall | q.f.fbrk | q.f.istall;

    always_comb begin
        d         = q;
        d.stop    = 1'b0;
        d.restart = 1'b0;
        d.term    = 1'b0;
        pend      = 1'b0;

        // datapath events first; bus actions below take precedence
        if (evt_mark)   d.f.mark = 1'b1;
        if (evt_int)    begin d.f.irq = 1'b1; d.f.istall = 1'b1; end
        if (evt_err[0]) d.f.err0 = 1'b1;
        if (evt_err[1]) d.f.err1 = 1'b1;

        if (wr_en && sel_mark) begin
            d.markv  = wdata[MARK_W-1:0];
            d.f.mark = 1'b0;
        end
        if (wr_en && sel_err)  d.errv = wdata[ERR_W-1:0];
        if (wr_en && sel_mode) d.mode = wdata[MODE_W-1:0];

        if (SECOND_INST && wr_en && sel_stat) begin
            if ((wdata[DIR_BIT] != q.f.dir) && dma_active &&
                (dma_qwc_nz || !(stalled_q || q.f.irq)))
                d.term = 1'b1;
            d.f.dir = wdata[DIR_BIT];
            if (wdata[DIR_BIT]) begin
                d.fqc = dl_clamped;
            end else begin
                d.fqc = '0;
                if (dma_active) d.restart = 1'b1;
            end
        end

        if (wr_en && sel_cmd) begin
            if (wdata[CMD_FBK]) begin
                d.f.fbrk = 1'b1;
                d.stop   = 1'b1;
            end
            if (wdata[CMD_STP]) d.f.sstall = 1'b1;
            if (wdata[CMD_STC]) begin
                pend       = d.f.sstall | d.f.fbrk | d.f.istall;
                d.f.sstall = 1'b0;
                d.f.fbrk   = 1'b0;
                d.f.istall = 1'b0;
                d.f.irq    = 1'b0;
                d.f.err0   = 1'b0;
                d.f.err1   = 1'b0;
                if (pend && dma_active && (!SECOND_INST || !q.f.dir))
                    d.restart = 1'b1;
            end
            if (wdata[CMD_RST]) begin
                d.f    = '0;
                d.fqc  = '0;
                d.errv = '0;
            end
        end

        d.f.ps = (d.f.sstall | d.f.fbrk | d.f.istall) ? 2'b00 : proc_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dma_stop    = q.stop;
    assign dma_restart = q.restart;
    assign dma_term    = q.term;
    assign flags_q     = q.f;
    assign fqc_q       = q.fqc;

    always_comb begin
        rdata = '0;
        if (sel_stat) rdata = {{TOP_W{1'b0}}, q.fqc, {GAP_W{1'b0}}, q.f};
        if (sel_err)  rdata = {{(32-ERR_W){1'b0}}, q.errv};
        if (sel_mode) rdata = {{(32-MODE_W){1'b0}}, q.mode};
        if (sel_mark) rdata = {{(32-MARK_W){1'b0}}, q.markv};
        for (int i = 0; i < NFILL; i++) begin
            if (row_sel[i]) rdata = fill_row[i*32 +: 32];
            if (col_sel[i]) rdata = fill_col[i*32 +: 32];
        end
    end
endmodule

// File: rtl/vpu_feed_csr_chk.sv
module vpu_feed_csr_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NFILL  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [31:0]         wdata,
    input logic [9:0]          flags,
    input logic [4:0]          fqc,
    input logic                dma_stop,
    input logic                dma_restart,
    input logic [NFILL*32-1:0] fill_row,
    input logic [NFILL*32-1:0] fill_col
);
    localparam int unsigned IDX_W = ADDR_W - 4;

    logic cmd_wr, stat_wr, mark_wr;
    assign cmd_wr  = wr_en && (addr[ADDR_W-1:4] == IDX_W'(1));
    assign stat_wr = wr_en && (addr[ADDR_W-1:4] == IDX_W'(0));
    assign mark_wr = wr_en && (addr[ADDR_W-1:4] == IDX_W'(3));

    AST_FBRK_SETS_AND_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata[1] && !wdata[0] && !wdata[3] |=> flags[5] && dma_stop); // R3

    AST_STALL_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[4] || flags[5] || flags[6]) |-> flags[1:0] == 2'b00); // R3

    AST_STOP_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata[2] && !wdata[1] && !wdata[0] && !wdata[3] |=> flags[4] && !dma_stop); // R4

    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata[3] && !wdata[2] && !wdata[1] |=> flags[9:4] == 6'd0); // R5

    AST_RESTART_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_restart |-> $past(cmd_wr) || $past(stat_wr)); // R6

    AST_RESET_KEEPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata[0] |=> $stable(fill_row) && $stable(fill_col)); // R7

    AST_MARK_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        mark_wr |=> !flags[2]); // R8

    AST_FQC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fqc <= 5'd16); // R10
endmodule

bind vpu_feed_csr vpu_feed_csr_chk #(.ADDR_W(ADDR_W), .NFILL(NFILL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .flags       (flags_q),
    .fqc         (fqc_q),
    .dma_stop    (dma_stop),
    .dma_restart (dma_restart),
    .fill_row    (fill_row),
    .fill_col    (fill_col)
);

// File: tb/tb_vpu_feed_csr.sv
module tb_vpu_feed_csr;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [1:0]   proc_state = 2'd0;
    logic         evt_mark = 1'b0, evt_int = 1'b0;
    logic [1:0]   evt_err = 2'd0;
    logic         dma_active = 1'b0, dma_qwc_nz = 1'b0;
    logic [7:0]   dl_size = 8'd0;
    logic         dma_stop, dma_restart, dma_term;
    logic [127:0] fill_row, fill_col;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vpu_feed_csr dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
        .wdata (wdata), .rdata (rdata), .proc_state (proc_state),
        .evt_mark (evt_mark), .evt_int (evt_int), .evt_err (evt_err),
        .dma_active (dma_active), .dma_qwc_nz (dma_qwc_nz),
        .dl_size (dl_size), .dma_stop (dma_stop),
        .dma_restart (dma_restart), .dma_term (dma_term),
        .fill_row (fill_row), .fill_col (fill_col)
    );

    // {is_write, addr, data, expected read}
    localparam int NV = 19;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h80, 32'h1111_1111, 32'h0},
        {1'b1, 8'h90, 32'h2222_2222, 32'h0},
        {1'b1, 8'hA0, 32'h3333_3333, 32'h0},
        {1'b1, 8'hB0, 32'h4444_4444, 32'h0},
        {1'b1, 8'hC0, 32'hA5A5_A5A5, 32'h0},
        {1'b1, 8'hF0, 32'h5A5A_5A5A, 32'h0},
        {1'b0, 8'h80, 32'h0, 32'h1111_1111},
        {1'b0, 8'hB0, 32'h0, 32'h4444_4444},
        {1'b0, 8'hC0, 32'h0, 32'hA5A5_A5A5},
        {1'b0, 8'hD0, 32'h0, 32'h0},
        {1'b0, 8'hF0, 32'h0, 32'h5A5A_5A5A},
        {1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h20, 32'h0, 32'h7},
        {1'b1, 8'h40, 32'h0000_0003, 32'h0},
        {1'b0, 8'h40, 32'h0, 32'h3},
        {1'b1, 8'h30, 32'hABCD_1234, 32'h0},
        {1'b0, 8'h30, 32'h0, 32'h1234},
        {1'b0, 8'h50, 32'h0, 32'h0},
        {1'b0, 8'h10, 32'h0, 32'h0}
    };

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata, exp, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, 32'h0, "R1 status after reset");
        rd(8'h80, 32'h0, "R1 row0 after reset");
        chk({31'd0, dma_stop | dma_restart | dma_term}, 32'h0, "R1 pulses idle");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                wr(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                rd(VEC[i][71:64], VEC[i][31:0],
                   VEC[i][71:64] >= 8'h80 ? "R2 fill readback" :
                   (VEC[i][71:64] == 8'h50 || VEC[i][71:64] == 8'h10) ?
                   "R12 unused or command reads zero" : "R13 plain register readback");
            end
        end

        proc_state = 2'd2;
        rd(8'h00, 32'h2, "R3 state follows datapath when not stalled");

        // force break
        wr(8'h10, 32'h2);
        chk({31'd0, dma_stop}, 32'h1, "R3 dma_stop pulse in cycle after write");
        rd(8'h00, 32'h20, "R3 force-break flag and idle state");
        chk({31'd0, dma_stop}, 32'h0, "R3 dma_stop lasts one cycle");

        // cancel with pending stall, channel active, direction 0
        dma_active = 1'b1;
        wr(8'h10, 32'h8);
        chk({31'd0, dma_restart}, 32'h1, "R6 restart after real stall");
        rd(8'h00, 32'h2, "R5 cancel clears stall flags");

        wr(8'h10, 32'h8);
        chk({31'd0, dma_restart}, 32'h0, "R6 no restart without pending stall");

        // stop
        wr(8'h10, 32'h4);
        chk({31'd0, dma_stop}, 32'h0, "R4 stop does not abort the channel");
        rd(8'h00, 32'h10, "R4 stop-stall flag and idle state");

        // interrupt and error events
        @(negedge clk); evt_int = 1'b1; evt_err = 2'b11;
        @(negedge clk); evt_int = 1'b0; evt_err = 2'b00;
        rd(8'h00, 32'h3D0, "R8 interrupt and error events set flags");

        // status write of all ones: only direction moves; stalled, no quadwords
        dl_size = 8'd20;
        wr(8'h00, 32'hFFFF_FFFF);
        chk({31'd0, dma_term}, 32'h0, "R11 no terminate while stalled and empty");
        rd(8'h00, 32'h1000_03D8, "R9 only direction writable, R10 count clamps to 16");

        wr(8'h10, 32'h8);
        chk({31'd0, dma_restart}, 32'h0, "R6 no restart with direction set");
        rd(8'h00, 32'h1000_000A, "R5 cancel with direction set");

        wr(8'h00, 32'h0);
        chk({30'd0, dma_term, dma_restart}, 32'h3, "R11 terminate and R10 restart on clear");
        rd(8'h00, 32'h2, "R10 clearing direction zeroes the count");

        dl_size = 8'd9;
        dma_qwc_nz = 1'b1;
        wr(8'h00, 32'h8);
        chk({30'd0, dma_term, dma_restart}, 32'h2, "R11 terminate on set, no restart");
        rd(8'h00, 32'h0900_000A, "R10 count loads download size below 16");

        // mark
        @(negedge clk); evt_mark = 1'b1;
        @(negedge clk); evt_mark = 1'b0;
        rd(8'h00, 32'h0900_000E, "R8 mark event sets flag");
        wr(8'h30, 32'h55);
        rd(8'h00, 32'h0900_000A, "R8 mark write clears flag");

        // command reset
        wr(8'h10, 32'h1);
        rd(8'h00, 32'h2, "R7 reset clears status, direction and count");
        rd(8'h20, 32'h0, "R7 reset clears error register");
        rd(8'h80, 32'h1111_1111, "R7 row word kept");
        rd(8'hF0, 32'h5A5A_5A5A, "R7 column word kept");
        rd(8'h40, 32'h3, "R7 mode kept");
        chk(fill_row[63:32], 32'h2222_2222, "R2 row word on fill output");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule